// File: doc/BRIEF.md
# Pad Configuration and Ownership Cell

This cell sits beside one general-purpose pad. It holds the static settings for that pad and decides which side drives it. A 13-bit configuration word arrives one bit at a time through a serial stage. The pad's active settings change only when a separate load strobe copies the whole stage across. Because the serial output is the last bit of the stage, many cells can be chained on one serial line and then loaded together.

The active word has several uses. It chooses the owner of the pad: the user project or management. It can block output and input. It selects one of eight drive modes, and the mode is decoded into flags for the pad circuitry. The remaining analog, slew, threshold and hold bits are passed through unchanged.

When management owns the pad, a special function takes precedence over the plain management data bit. The pad input goes back to both the user side and the management side, and it is forced to 0 while input is disabled.

Top module: `pad_config_cell`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) sets the active word to the parameter `DEF_CFG` (default 13'h1803) and clears the serial stage, so `ser_out` reads 0.
- R2: On each clock edge where `ser_shift` is 1, the serial stage moves one place towards its MSB and takes `ser_in` into bit 0. `ser_out` is stage bit 12, so a word sent MSB first (bit 12 first) sits in place after 13 shifts and then leaves MSB first.
- R3: Shifting without a load does not change any pad control output.
- R4: A clock edge with `ser_load` at 1 copies all 13 stage bits into the active word. If a shift happens on the same edge, the copy takes the stage contents from before that shift.
- R5: Active-word fields: bit 0 is owner (1 = management), bit 1 is output disable, bit 2 is hold override, bit 3 is input disable, bit 4 is buffer mode, bits 5/6/7 are analog enable/select/polarity, bit 8 is slow slew, bit 9 is trip point, and bits 12:10 are the drive mode. Each field appears on its own output.
- R6: Drive-mode decode: 000/001 sets `ana_mode`, 010/011 sets `pull_up`, 100/101 sets `open_drain`, 111 sets `weak_drive`, and 110 sets none of the four flags.
- R7: With owner 0, `pad_out` equals `usr_out` and `pad_oeb` equals `usr_oeb` OR the output-disable bit. The management inputs have no effect.
- R8: With owner 1 and `sf_en` 1, `pad_out` equals `sf_out` and `pad_oeb` equals `sf_oeb` OR output disable. The user inputs and `mgmt_dat` have no effect.
- R9: With owner 1 and `sf_en` 0, `pad_out` equals `mgmt_dat` and `pad_oeb` equals the output-disable bit.
- R10: `usr_in` and `mgmt_in` both equal `pad_in` when input disable is 0, and both are 0 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset to the default configuration |
| ser_in | input | 1 | Serial configuration data in |
| ser_shift | input | 1 | Advance the serial stage one bit |
| ser_load | input | 1 | Copy the serial stage into the active word |
| ser_out | output | 1 | Serial data out to the next cell |
| usr_out | input | 1 | User output value |
| usr_oeb | input | 1 | User output enable, active low |
| usr_in | output | 1 | Pad input returned to the user |
| sf_en | input | 1 | Management special function active |
| sf_out | input | 1 | Special function output value |
| sf_oeb | input | 1 | Special function output enable, active low |
| mgmt_dat | input | 1 | Plain management data bit |
| mgmt_in | output | 1 | Pad input returned to management |
| pad_in | input | 1 | Value seen at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oeb | output | 1 | Pad output enable, active low |
| hold_ovr | output | 1 | Hold override bit |
| buf_mode | output | 1 | Input buffer mode bit |
| ana_en | output | 1 | Analog enable bit |
| ana_sel | output | 1 | Analog select bit |
| ana_pol | output | 1 | Analog polarity bit |
| slow_slew | output | 1 | Slow slew bit |
| trip_sel | output | 1 | Trip point bit |
| drive_mode | output | 3 | Raw drive mode field |
| ana_mode | output | 1 | Drive mode is analog |
| pull_up | output | 1 | Drive mode is input with pull-up |
| open_drain | output | 1 | Drive mode is open drain |
| weak_drive | output | 1 | Drive mode is weak output |

## Verification
Results fall into two timing groups.

Serial shifts, loads and resets are registered. Their effect is due on the first clock edge after the control is seen. The bench drives each control just after a falling edge and checks the result at the next falling edge, which is half a period after the rising edge that acts on it.

The ownership routing and the input gating are combinational from the active word and the pin inputs. The bench changes those inputs mid-period and samples a few nanoseconds later, with no clock edge in between. The "ignored" cases are checked by changing the non-owning side's inputs to values that differ from the owner's and confirming that `pad_out` and `pad_oeb` do not move.

// File: rtl/padcfg_pkg.sv
// Package: shared widths and field positions of the pad configuration word.
// Assumes: the word layout is fixed by the pad circuitry that decodes it.
package padcfg_pkg;
    localparam int CFG_W    = 13;
    localparam int B_OWNER  = 0;
    localparam int B_ODIS   = 1;
    localparam int B_HOLD   = 2;
    localparam int B_IDIS   = 3;
    localparam int B_BUFM   = 4;
    localparam int B_AEN    = 5;
    localparam int B_ASEL   = 6;
    localparam int B_APOL   = 7;
    localparam int B_SLEW   = 8;
    localparam int B_TRIP   = 9;
    localparam int DM_LSB   = 10;
    localparam int DM_W     = 3;

    typedef enum logic [DM_W-1:0] {
        DM_ANALOG_A = 3'b000,
        DM_ANALOG_B = 3'b001,
        DM_PULLUP_A = 3'b010,
        DM_PULLUP_B = 3'b011,
        DM_OD_HIGH  = 3'b100,
        DM_OD_LOW   = 3'b101,
        DM_STRONG   = 3'b110,
        DM_WEAK     = 3'b111
    } drive_e;
endpackage

// File: rtl/padcfg_shift.sv
// Module: serial shift stage of the configuration word.
// Does: moves the word up one bit per enabled edge; the top bit is the chain output.
// Assumes: ser_shift is a single-cycle enable that is synchronous to clk.
module padcfg_shift #(
    parameter int W = padcfg_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] stage,
    output logic         dout
);
    // Shift towards the MSB, taking new data in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage <= '0;
        else if (shift_en) stage <= {stage[W-2:0], din};
    end

    assign dout = stage[W-1];

    assert_shift_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (stage[0] == $past(din)) && (dout == $past(stage[W-2])));
    assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && $past(rst_n)) |=> $stable(stage));
endmodule

// File: rtl/padcfg_hold.sv
// Module: active configuration register.
// Does: captures the whole serial stage on a load; on reset it holds DEF.
// Assumes: stage_in is the registered output of the shift stage.
module padcfg_hold #(
    parameter int           W   = padcfg_pkg::CFG_W,
    parameter logic [W-1:0] DEF = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] stage_in,
    output logic [W-1:0] active
);
    // Parallel copy on load, default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= DEF;
        else if (load) active <= stage_in;
    end

    assert_reset_default_R1: assert property (@(posedge clk)
        !rst_n |=> active == DEF);
    assert_no_load_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(active));
    assert_load_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active == $past(stage_in));
endmodule

// File: rtl/padcfg_route.sv
// Module: field decode and pad ownership multiplexer.
// Does: splits the active word into controls, decodes the drive mode and picks
//       the pad driver by priority: user, then special function, then data bit.
// Assumes: purely combinational; every input is stable within a cycle.
module padcfg_route
    import padcfg_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             usr_out,
    input  logic             usr_oeb,
    input  logic             sf_en,
    input  logic             sf_out,
    input  logic             sf_oeb,
    input  logic             mgmt_dat,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oeb,
    output logic             usr_in,
    output logic             mgmt_in,
    output logic [DM_W-1:0]  drive_mode,
    output logic             ana_mode,
    output logic             pull_up,
    output logic             open_drain,
    output logic             weak_drive
);
    logic   owner_mgmt;
    logic   out_dis;
    logic   in_dis;
    drive_e dm;

    assign owner_mgmt = cfg[B_OWNER];
    assign out_dis    = cfg[B_ODIS];
    assign in_dis     = cfg[B_IDIS];
    assign dm         = drive_e'(cfg[DM_LSB +: DM_W]);
    assign drive_mode = cfg[DM_LSB +: DM_W];

    // Drive-mode flags for the pad circuitry.
    always_comb begin
        ana_mode   = 1'b0;
        pull_up    = 1'b0;
        open_drain = 1'b0;
        weak_drive = 1'b0;
        unique case (dm)
            DM_ANALOG_A, DM_ANALOG_B: ana_mode   = 1'b1;
            DM_PULLUP_A, DM_PULLUP_B: pull_up    = 1'b1;
            DM_OD_HIGH,  DM_OD_LOW:   open_drain = 1'b1;
            DM_WEAK:                  weak_drive = 1'b1;
            default: ;
        endcase
    end

    // Three-level ownership priority for the pad driver.
    always_comb begin
        if (!owner_mgmt) begin
            pad_out = usr_out;
            pad_oeb = usr_oeb | out_dis;
        end else if (sf_en) begin
            pad_out = sf_out;
            pad_oeb = sf_oeb | out_dis;
        end else begin
            pad_out = mgmt_dat;
            pad_oeb = out_dis;
        end
    end

    // Input return path, blocked by input disable.
    assign usr_in  = pad_in & ~in_dis;
    assign mgmt_in = pad_in & ~in_dis;
endmodule

// File: rtl/pad_config_cell.sv
// Module: per-pad configuration cell (top).
// Does: a serial stage, an active word loaded from it, and decode/ownership routing.
// Assumes: a single clock; ser_shift and ser_load are synchronous enables.
module pad_config_cell
    import padcfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_CFG = 13'h1803
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_in,
    input  logic        ser_shift,
    input  logic        ser_load,
    output logic        ser_out,
    input  logic        usr_out,
    input  logic        usr_oeb,
    output logic        usr_in,
    input  logic        sf_en,
    input  logic        sf_out,
    input  logic        sf_oeb,
    input  logic        mgmt_dat,
    output logic        mgmt_in,
    input  logic        pad_in,
    output logic        pad_out,
    output logic        pad_oeb,
    output logic        hold_ovr,
    output logic        buf_mode,
    output logic        ana_en,
    output logic        ana_sel,
    output logic        ana_pol,
    output logic        slow_slew,
    output logic        trip_sel,
    output logic [2:0]  drive_mode,
    output logic        ana_mode,
    output logic        pull_up,
    output logic        open_drain,
    output logic        weak_drive
);
    logic [CFG_W-1:0] stage;
    logic [CFG_W-1:0] active;

    padcfg_shift #(.W(CFG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(ser_shift), .din(ser_in),
        .stage(stage), .dout(ser_out)
    );

    padcfg_hold #(.W(CFG_W), .DEF(DEF_CFG)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .stage_in(stage),
        .active(active)
    );

    padcfg_route u_route (
        .cfg(active), .usr_out(usr_out), .usr_oeb(usr_oeb),
        .sf_en(sf_en), .sf_out(sf_out), .sf_oeb(sf_oeb),
        .mgmt_dat(mgmt_dat), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oeb(pad_oeb),
        .usr_in(usr_in), .mgmt_in(mgmt_in),
        .drive_mode(drive_mode), .ana_mode(ana_mode), .pull_up(pull_up),
        .open_drain(open_drain), .weak_drive(weak_drive)
    );

    // Pass-through bits for circuitry outside this cell.
    assign hold_ovr  = active[B_HOLD];
    assign buf_mode  = active[B_BUFM];
    assign ana_en    = active[B_AEN];
    assign ana_sel   = active[B_ASEL];
    assign ana_pol   = active[B_APOL];
    assign slow_slew = active[B_SLEW];
    assign trip_sel  = active[B_TRIP];

    assert_user_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active[B_OWNER] && !usr_oeb && !active[B_ODIS]) |-> (pad_out == usr_out && !pad_oeb));
    assert_sf_owns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active[B_OWNER] && sf_en) |-> (pad_out == sf_out));
    assert_data_owns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active[B_OWNER] && !sf_en) |-> (pad_out == mgmt_dat && pad_oeb == active[B_ODIS]));
    assert_input_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        active[B_IDIS] |-> (!usr_in && !mgmt_in));
    assert_mode_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ana_mode, pull_up, open_drain, weak_drive}));
endmodule

// File: tb/pad_config_cell_tb.sv
module pad_config_cell_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, ser_shift = 1'b0, ser_load = 1'b0, ser_out;
    logic usr_out = 1'b0, usr_oeb = 1'b1, usr_in;
    logic sf_en = 1'b0, sf_out = 1'b0, sf_oeb = 1'b1, mgmt_dat = 1'b0, mgmt_in;
    logic pad_in = 1'b0, pad_out, pad_oeb;
    logic hold_ovr, buf_mode, ana_en, ana_sel, ana_pol, slow_slew, trip_sel;
    logic [2:0] drive_mode;
    logic ana_mode, pull_up, open_drain, weak_drive;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pad_config_cell #(.DEF_CFG(13'h1803)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_shift(ser_shift),
        .ser_load(ser_load), .ser_out(ser_out),
        .usr_out(usr_out), .usr_oeb(usr_oeb), .usr_in(usr_in),
        .sf_en(sf_en), .sf_out(sf_out), .sf_oeb(sf_oeb), .mgmt_dat(mgmt_dat),
        .mgmt_in(mgmt_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oeb(pad_oeb),
        .hold_ovr(hold_ovr), .buf_mode(buf_mode), .ana_en(ana_en), .ana_sel(ana_sel),
        .ana_pol(ana_pol), .slow_slew(slow_slew), .trip_sel(trip_sel),
        .drive_mode(drive_mode), .ana_mode(ana_mode), .pull_up(pull_up),
        .open_drain(open_drain), .weak_drive(weak_drive)
    );

    typedef struct packed {
        logic [12:0] cfg;
        logic        u_out, u_oeb, s_en, s_out, s_oeb, m_dat, p_in;
        logic        e_out, e_oeb, e_in;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{13'h1800, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1}, // R7 user drives
        '{13'h1800, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R7 user oeb
        '{13'h1802, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R7 cfg disable
        '{13'h1801, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b1}, // R9 data bit
        '{13'h1801, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R8 special fn
        '{13'h1801, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R8 sf oeb
        '{13'h1809, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0}, // R10 mgmt blocked
        '{13'h1808, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0}  // R10 user blocked
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [12:0] w);
        for (int i = 12; i >= 0; i--) begin
            ser_in = w[i];
            ser_shift = 1'b1;
            @(negedge clk);
        end
        ser_shift = 1'b0;
    endtask

    task automatic load_pulse();
        ser_load = 1'b1;
        @(negedge clk);
        ser_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: default 13'h1803 = management owner, output disabled, drive 110.
        chk("R1 ser_out after reset", ser_out, 0);
        chk("R1 drive_mode default", drive_mode, 3'b110);
        mgmt_dat = 1'b1; #2;
        chk("R1 owner default mgmt", pad_out, 1);
        chk("R1 oeb default", pad_oeb, 1);
        mgmt_dat = 1'b0;

        // Table walk: routing and input gating.
        for (int v = 0; v < NV; v++) begin
            shift_word(VECS[v].cfg);
            load_pulse();
            usr_out = VECS[v].u_out; usr_oeb = VECS[v].u_oeb;
            sf_en = VECS[v].s_en; sf_out = VECS[v].s_out; sf_oeb = VECS[v].s_oeb;
            mgmt_dat = VECS[v].m_dat; pad_in = VECS[v].p_in;
            #3;
            chk("R7/R8/R9 pad_out", pad_out, VECS[v].e_out);
            chk("R7/R8/R9 pad_oeb", pad_oeb, VECS[v].e_oeb);
            chk("R10 usr_in", usr_in, VECS[v].e_in);
            chk("R10 mgmt_in", mgmt_in, VECS[v].e_in);
        end

        // R7: with user owner, management inputs toggled have no effect.
        shift_word(13'h1800); load_pulse();
        usr_out = 1'b0; usr_oeb = 1'b0; sf_en = 1'b1; sf_out = 1'b1; sf_oeb = 1'b1; mgmt_dat = 1'b1;
        #3;
        chk("R7 mgmt ignored out", pad_out, 0);
        chk("R7 mgmt ignored oeb", pad_oeb, 0);

        // R8: user and data inputs ignored while the special function owns the pad.
        shift_word(13'h1801); load_pulse();
        sf_en = 1'b1; sf_out = 1'b0; sf_oeb = 1'b0; usr_out = 1'b1; usr_oeb = 1'b1; mgmt_dat = 1'b1;
        #3;
        chk("R8 others ignored out", pad_out, 0);
        chk("R8 others ignored oeb", pad_oeb, 0);

        // R3: shift a new word without a load; controls stay as loaded (13'h1801).
        @(negedge clk);
        shift_word(13'h0C0A);
        chk("R3 drive_mode held", drive_mode, 3'b110);
        chk("R3 oeb held", pad_oeb, 0);
        chk("R3 pull_up held", pull_up, 0);

        // R2: stage now holds 13'h0C0A; ser_out gives it MSB first.
        chk("R2 ser_out bit12", ser_out, 0);
        for (int k = 1; k <= 4; k++) begin
            ser_in = 1'b0; ser_shift = 1'b1;
            @(negedge clk);
            ser_shift = 1'b0;
            chk("R2 ser_out chain", ser_out, (13'h0C0A >> (12 - k)) & 1);
        end

        // R4: load together with a shift copies the pre-shift stage.
        shift_word(13'h17F4);
        ser_in = 1'b1; ser_shift = 1'b1; ser_load = 1'b1;
        @(negedge clk);
        ser_shift = 1'b0; ser_load = 1'b0;
        chk("R4 load beats shift drive", drive_mode, 3'b101);

        // R5/R6: 13'h17F4 sets bits 2,4..9 and drive 101 (open drain).
        chk("R5 hold_ovr", hold_ovr, 1);
        chk("R5 buf_mode", buf_mode, 1);
        chk("R5 analog bits", {ana_en, ana_sel, ana_pol}, 3'b111);
        chk("R5 slew/trip", {slow_slew, trip_sel}, 2'b11);
        chk("R6 open drain flags", {ana_mode, pull_up, open_drain, weak_drive}, 4'b0010);

        shift_word(13'h0000); load_pulse();
        chk("R5 fields clear", {hold_ovr, buf_mode, ana_en, ana_sel, ana_pol, slow_slew, trip_sel}, 0);
        chk("R6 analog flags", {ana_mode, pull_up, open_drain, weak_drive}, 4'b1000);
        shift_word(13'h0C00); load_pulse();
        chk("R6 pull-up flags", {ana_mode, pull_up, open_drain, weak_drive}, 4'b0100);
        shift_word(13'h1C00); load_pulse();
        chk("R6 weak flags", {ana_mode, pull_up, open_drain, weak_drive}, 4'b0001);
        shift_word(13'h1800); load_pulse();
        chk("R6 strong no flags", {ana_mode, pull_up, open_drain, weak_drive}, 4'b0000);

        // R1: reset in mid-operation restores the default.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset restores drive", drive_mode, 3'b110);
        chk("R1 reset clears ser_out", ser_out, 0);
        sf_en = 1'b0; mgmt_dat = 1'b0; #2;
        chk("R1 reset restores owner", pad_out, 0);
        chk("R1 reset restores oeb", pad_oeb, 1);

        finish_run();
    end
endmodule